// File: doc/BRIEF.md
# Stepped LFSR Cascade Keystream Generator

The block holds two Fibonacci-style shift registers in a chain. The upstream register is the control register. It moves one position on every keystream step, and the bit it shifts out sets the pace of the downstream data register. The data register moves one position when that bit is 1 and two positions when it is 0. Both moves complete inside one clock. The bit that the data register shifts out on the step is the keystream bit.

Software or a key-setup engine first loads both registers through the seed ports with a load strobe. After that, each cycle with the step input high produces one keystream bit, flagged valid for one cycle. A seed of all zeros is replaced by a nonzero constant, so neither register can stall in the all-zero state. Register lengths and tap masks are parameters.

Top module: `stepped_lfsr_cascade`

## Requirements
- R1: After reset, `ks_o` and `ks_valid_o` are 0. Steps requested before the first load are ignored: no valid pulse and no register movement.
- R2: A load copies `ctrl_seed_i` and `data_seed_i` into the two registers. A seed equal to zero is stored as the value 1 instead, meaning only cell 0 is set.
- R3: One advance of a register moves cell i+1 into cell i for every i. The leftmost cell (index width-1) receives the XOR of the cells selected by the tap mask. The default masks select cells 0 and 2 of the 5-cell control register and cells 0 and 1 of the 7-cell data register.
- R4: On every accepted step the control register advances exactly once. Its control bit is cell 0 as it stood before that advance.
- R5: On an accepted step the data register advances once when the control bit is 1 and twice when it is 0, with both advances in the same clock.
- R6: The keystream bit is data cell 0 as it stood before the step. It appears on `ks_o` in the cycle after the step, with `ks_valid_o` high for that one cycle only.
- R7: Load has priority over step. A cycle with both strobes only loads: there is no advance and `ks_valid_o` is low in the next cycle.
- R8: In cycles without a step, both registers hold and `ks_o` keeps its last value, so the keystream resumes unchanged after an idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load strobe for both seeds |
| ctrl_seed_i | input | CTRL_W | Seed for the control register |
| data_seed_i | input | DATA_W | Seed for the data register |
| step_i | input | 1 | Request one keystream step |
| ks_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | High for one cycle per accepted step |

## Verification
The bench builds the block with its default parameters: a 5-cell control register with taps on cells 0 and 2, and a 7-cell data register with taps on cells 0 and 1. These short lengths let a few thousand random steps cover many full periods of both registers. As a result, runs of repeated control bits, and so runs of double advances, occur often. Zero seeds, loads that coincide with steps, steps before any load and long idle gaps are driven both on purpose and at random.

// File: rtl/stepped_lfsr_cascade_pkg.sv
`timescale 1ns/1ps
package stepped_lfsr_cascade_pkg;
  typedef enum logic {ADV_TWO = 1'b0, ADV_ONE = 1'b1} adv_mode_e;
  localparam int unsigned MAX_ADV_CTRL = 1;
  localparam int unsigned MAX_ADV_DATA = 2;
endpackage

// File: rtl/lfsr_bank.sv
`timescale 1ns/1ps
module lfsr_bank #(
  parameter int unsigned WIDTH    = 5,
  parameter logic [WIDTH-1:0] TAP_MASK = 5'b00101,
  parameter int unsigned MAX_ADV  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic             adv_i,
  input  logic             two_i,
  output logic [WIDTH-1:0] state_o,
  output logic             out_bit_o
);
  localparam logic [WIDTH-1:0] FILL = WIDTH'(1);

  function automatic logic [WIDTH-1:0] shift1(input logic [WIDTH-1:0] s);
    return {^(s & TAP_MASK), s[WIDTH-1:1]};
  endfunction

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] chain [MAX_ADV+1];
  logic [WIDTH-1:0] adv_val;

  assign chain[0] = state_q;
  for (genvar k = 0; k < MAX_ADV; k++) begin : g_chain
    assign chain[k+1] = shift1(chain[k]);
  end

  if (MAX_ADV >= 2) begin : g_two
    assign adv_val = two_i ? chain[2] : chain[1];
  end else begin : g_one
    logic unused_two;
    assign unused_two = two_i;
    assign adv_val = chain[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= FILL;
    else if (load_i)  state_q <= (seed_i == '0) ? FILL : seed_i;
    else if (adv_i)   state_q <= adv_val;
  end

  assign state_o   = state_q;
  assign out_bit_o = state_q[0];
endmodule

// File: rtl/ks_out_stage.sv
`timescale 1ns/1ps
module ks_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  input  logic bit_i,
  output logic loaded_o,
  output logic ks_o,
  output logic ks_valid_o
);
  logic loaded_q, ks_q, vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      ks_q     <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (load_i) begin
        loaded_q <= 1'b1;
      end else if (step_i && loaded_q) begin
        ks_q  <= bit_i;
        vld_q <= 1'b1;
      end
    end
  end

  assign loaded_o   = loaded_q;
  assign ks_o       = ks_q;
  assign ks_valid_o = vld_q;
endmodule

// File: rtl/stepped_lfsr_cascade.sv
`timescale 1ns/1ps
module stepped_lfsr_cascade
  import stepped_lfsr_cascade_pkg::*;
#(
  parameter int unsigned CTRL_W = 5,
  parameter logic [CTRL_W-1:0] CTRL_TAPS = 5'b00101,
  parameter int unsigned DATA_W = 7,
  parameter logic [DATA_W-1:0] DATA_TAPS = 7'b0000011
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CTRL_W-1:0] ctrl_seed_i,
  input  logic [DATA_W-1:0] data_seed_i,
  input  logic              step_i,
  output logic              ks_o,
  output logic              ks_valid_o
);
  logic              loaded;
  logic              adv;
  logic              ctrl_bit, data_bit;
  logic [CTRL_W-1:0] ctrl_state;
  logic [DATA_W-1:0] data_state;
  adv_mode_e         mode;

  assign adv  = step_i & loaded;
  assign mode = adv_mode_e'(ctrl_bit);

  lfsr_bank #(.WIDTH(CTRL_W), .TAP_MASK(CTRL_TAPS), .MAX_ADV(MAX_ADV_CTRL)) u_ctrl (
    .clk_i, .rst_ni, .load_i,
    .seed_i(ctrl_seed_i), .adv_i(adv), .two_i(1'b0),
    .state_o(ctrl_state), .out_bit_o(ctrl_bit)
  );

  lfsr_bank #(.WIDTH(DATA_W), .TAP_MASK(DATA_TAPS), .MAX_ADV(MAX_ADV_DATA)) u_data (
    .clk_i, .rst_ni, .load_i,
    .seed_i(data_seed_i), .adv_i(adv), .two_i(mode == ADV_TWO),
    .state_o(data_state), .out_bit_o(data_bit)
  );

  ks_out_stage u_out (
    .clk_i, .rst_ni, .load_i, .step_i,
    .bit_i(data_bit), .loaded_o(loaded), .ks_o, .ks_valid_o
  );
endmodule

// File: rtl/stepped_lfsr_cascade_chk.sv
`timescale 1ns/1ps
module stepped_lfsr_cascade_chk #(
  parameter int unsigned CTRL_W = 5,
  parameter int unsigned DATA_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic              step_i,
  input logic [CTRL_W-1:0] ctrl_seed_i,
  input logic [DATA_W-1:0] data_seed_i,
  input logic              ks_o,
  input logic              ks_valid_o,
  input logic              loaded,
  input logic [CTRL_W-1:0] ctrl_state,
  input logic [DATA_W-1:0] data_state
);
  a_r2_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_state != '0) && (data_state != '0));

  a_r2_zero_seed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && data_seed_i == '0) |=> (data_state == DATA_W'(1)));

  a_r4_ctrl_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && loaded && !load_i) |=> (ctrl_state[CTRL_W-2:0] == $past(ctrl_state[CTRL_W-1:1])));

  a_r5_data_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && loaded && !load_i && ctrl_state[0]) |=>
      (data_state[DATA_W-2:0] == $past(data_state[DATA_W-1:1])));

  a_r5_data_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && loaded && !load_i && !ctrl_state[0]) |=>
      (data_state[DATA_W-3:0] == $past(data_state[DATA_W-1:2])));

  a_r6_ks_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && loaded && !load_i) |=> (ks_valid_o && ks_o == $past(data_state[0])));

  a_r7_load_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !ks_valid_o);

  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(step_i && loaded)) |=>
      ($stable(data_state) && $stable(ctrl_state) && $stable(ks_o) && !ks_valid_o));
endmodule

bind stepped_lfsr_cascade stepped_lfsr_cascade_chk #(.CTRL_W(CTRL_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .step_i(step_i),
  .ctrl_seed_i(ctrl_seed_i), .data_seed_i(data_seed_i),
  .ks_o(ks_o), .ks_valid_o(ks_valid_o), .loaded(loaded),
  .ctrl_state(ctrl_state), .data_state(data_state)
);

// File: tb/stepped_lfsr_cascade_tb.sv
`timescale 1ns/1ps
module stepped_lfsr_cascade_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0, step = 1'b0;
  logic [4:0] cseed = '0;
  logic [6:0] dseed = '0;
  logic       ks, ks_vld;

  int checks = 0, fails = 0;
  bit done = 0;
  string req = "R1";

  logic [4:0] m_c = 5'd1;
  logic [6:0] m_d = 7'd1;
  bit   m_loaded = 0, m_v = 0, m_ks = 0;

  always #5 clk = ~clk;

  stepped_lfsr_cascade u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .ctrl_seed_i(cseed),
    .data_seed_i(dseed), .step_i(step), .ks_o(ks), .ks_valid_o(ks_vld)
  );

  // R3: taps on cells 0,2 (control) and 0,1 (data), shift toward cell 0
  function automatic logic [4:0] c_adv(input logic [4:0] s);
    return {s[0] ^ s[2], s[4:1]};
  endfunction
  function automatic logic [6:0] d_adv(input logic [6:0] s);
    return {s[0] ^ s[1], s[6:1]};
  endfunction

  task automatic model_edge();
    if (load) begin
      m_c = (cseed == 0) ? 5'd1 : cseed;
      m_d = (dseed == 0) ? 7'd1 : dseed;
      m_loaded = 1; m_v = 0;
    end else if (step && m_loaded) begin
      bit cb;
      cb = m_c[0];
      m_ks = m_d[0];
      m_c = c_adv(m_c);
      m_d = cb ? d_adv(m_d) : d_adv(d_adv(m_d));
      m_v = 1;
    end else m_v = 0;
  endtask

  task automatic check_out();
    checks++;
    if (ks_vld !== m_v || (m_v && ks !== m_ks)) begin
      fails++;
      $display("FAIL %s: valid=%0b ks=%0b expected valid=%0b ks=%0b", req, ks_vld, ks, m_v, m_ks);
    end
  endtask

  task automatic tick(input bit ld, input bit st, input logic [4:0] cs, input logic [6:0] ds);
    load = ld; step = st; cseed = cs; dseed = ds;
    @(posedge clk);
    model_edge();
    #1 check_out();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #22 rst_n = 1'b1;
    #1;
    // R1 reset values
    req = "R1"; checks++;
    if (ks !== 1'b0 || ks_vld !== 1'b0) begin
      fails++; $display("FAIL R1: ks=%0b valid=%0b expected 0 0", ks, ks_vld);
    end
    @(negedge clk);
    for (int i = 0; i < 6; i++) tick(0, 1, 5'h1f, 7'h55);
    // R2 zero seeds replaced by 1
    req = "R2";
    tick(1, 0, 5'd0, 7'd0);
    for (int i = 0; i < 30; i++) tick(0, 1, 0, 0);
    // R4/R5 control seed of all ones and lone bits
    req = "R4";
    tick(1, 0, 5'h1f, 7'h7f);
    for (int i = 0; i < 20; i++) tick(0, 1, 0, 0);
    req = "R5";
    tick(1, 0, 5'h10, 7'h40);
    for (int i = 0; i < 20; i++) tick(0, 1, 0, 0);
    // R7 load with step
    req = "R7";
    tick(0, 1, 0, 0);
    tick(1, 1, 5'h0a, 7'h33);
    for (int i = 0; i < 10; i++) tick(0, 1, 0, 0);
    // R8 idle gap
    req = "R8";
    for (int i = 0; i < 15; i++) tick(0, 0, 5'h1f, 7'h7f);
    for (int i = 0; i < 10; i++) tick(0, 1, 0, 0);
    // R6/R3 random mix
    for (int i = 0; i < 4000; i++) begin
      bit ld;
      logic [4:0] cs;
      logic [6:0] ds;
      req = (i % 2) ? "R6" : "R3";
      ld = ($urandom_range(0, 49) == 0);
      cs = ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom);
      ds = ($urandom_range(0, 7) == 0) ? 7'd0 : 7'($urandom);
      tick(ld, $urandom_range(0, 9) < 6, cs, ds);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule